// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Control-Flow Stall

This block reads 24-bit instruction words from a slow instruction memory and queues them for an execution unit. A memory access spans two clock cycles and returns two consecutive words, so one fetch cycle can queue two entries. The block keeps the running thread's program counter locally. After queueing any instruction that may change control flow or end the thread, it stops reading memory until the execution unit answers with a new address, a plain continue, or a suspend-complete signal.

Each time the sequencer stops it reports the address that follows the stopping instruction to the execution unit over a valid/ready port. A task-operand read (PULL) is rewritten into a SUSPEND when it is not the first PULL of the current task invocation and the task queue holds no further operand for that task. After a suspend completes, the block reports its PC again and waits idle for the start address of the next thread.

Top module: `ifetch_seq`

## Requirements
- R1: Reset empties the instruction queue (`fifoValid` low), drops any pending report (`pcRptValid` low), puts the block in the idle state (`threadIdle` high) and stops memory reads (`memRd` low).
- R2: While idle the block reads no memory; a `pcLoadValid` pulse in the idle state loads the PC, clears the first-PULL record and starts fetching at `pcLoadAddr`.
- R3: A fetch cycle holds `memRd` high with `memAddr` equal to the PC for two clocks; at the end of the second clock the word in `memRdData[23:0]` (address PC) is queued, followed by the word in `memRdData[47:24]` (address PC+1) unless the first word stops fetching.
- R4: Entries hold the opcode in bits [23:19], the operand mode in [18:16] and operand data in [15:0]. Opcodes 0x00, 0x01, 0x02, 0x03, 0x1C, 0x1D and 0x1F stop fetching once queued: nothing after them is queued and `memRd` stays low until the execution unit answers.
- R5: On every stop the block raises `pcRptValid` with `pcRptAddr` equal to the stopping instruction's address plus one, and holds both until `pcRptReady` is high at a clock edge.
- R6: The first PULL (0x01) queued after a thread start passes through unchanged, regardless of the task queue.
- R7: A later PULL with `taskMore` low is queued with bits [23:19] forced to 0x00 (SUSPEND) and bits [18:0] unchanged; with `taskMore` high it passes unchanged.
- R8: PUT (0x03), JMP (0x02), IFREG (0x1C), IFSTAT (0x1D) and START (0x1F) stop fetching but are always queued unchanged.
- R9: While stopped, a `pcLoadValid` pulse overwrites the PC and fetching restarts at `pcLoadAddr`; a `resumeGo` pulse restarts fetching at the stopping address plus one.
- R10: While stopped, a `suspendDone` pulse makes the block report its current PC on the report port and enter the idle state.
- R11: A fetch cycle starts only when the queue has room for two entries; no entry is lost or reordered while the execution unit drains slowly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 12 | Instruction memory read address (current PC) |
| memRd | output | 1 | Memory read in progress |
| memRdData | input | 48 | Words at memAddr (low half) and memAddr+1 (high half) |
| fifoData | output | 24 | Head entry of the instruction queue |
| fifoValid | output | 1 | Queue holds at least one entry |
| fifoPop | input | 1 | Execution unit takes the head entry |
| taskMore | input | 1 | Task queue holds another operand for the current task |
| pcLoadValid | input | 1 | New PC (start address or jump target) is present |
| pcLoadAddr | input | 12 | New PC value |
| resumeGo | input | 1 | Continue fetching after a stop without a PC change |
| suspendDone | input | 1 | Execution unit finished a suspend |
| pcRptValid | output | 1 | PC report pending |
| pcRptAddr | output | 12 | Reported PC |
| pcRptReady | input | 1 | Execution unit accepts the PC report |
| threadIdle | output | 1 | No thread running; waiting for a start PC |

## Verification
A queued entry becomes visible on `fifoData` one clock after the second cycle of its fetch, and a stop report appears in the same clock as the stopping entry; the bench therefore never checks entries at fixed cycles but records every popped entry and compares the recorded stream with a table afterwards. Reports are awaited with a bounded poll on `pcRptValid`, checked while the bench holds `pcRptReady` low, so the address is read while it is guaranteed stable. Absence checks (no reads while stopped, no reads while the queue is full) are sampled several clocks after the causing event, once any fetch cycle already under way has completed.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  localparam int OP_W  = 5;
  localparam int LANES = 2;

  localparam logic [OP_W-1:0] OP_SUSPEND = 5'h00;
  localparam logic [OP_W-1:0] OP_PULL    = 5'h01;
  localparam logic [OP_W-1:0] OP_JMP     = 5'h02;
  localparam logic [OP_W-1:0] OP_PUT     = 5'h03;
  localparam logic [OP_W-1:0] OP_IFREG   = 5'h1C;
  localparam logic [OP_W-1:0] OP_IFSTAT  = 5'h1D;
  localparam logic [OP_W-1:0] OP_START   = 5'h1F;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STALL
  } fetchState_t;

  // Strobes from the control FSM to the datapath, valid for one cycle.
  typedef struct packed {
    logic [LANES-1:0] push;   // queue lane word
    logic [LANES-1:0] sub;    // rewrite lane word into SUSPEND
    logic             pcLoad; // PC <= external address
    logic             pcAdv1; // PC <= PC + 1
    logic             pcAdv2; // PC <= PC + 2
    logic             rptSet; // latch next PC into the report register
  } fetchStrobe_t;

  function automatic logic isStallOp(input logic [OP_W-1:0] op);
    return (op == OP_SUSPEND) || (op == OP_PULL) || (op == OP_JMP) ||
           (op == OP_PUT) || (op == OP_IFREG) || (op == OP_IFSTAT) ||
           (op == OP_START);
  endfunction

endpackage

// File: rtl/ifetch_dp.sv
module ifetch_dp
  import ifetch_pkg::*;
#(
  parameter int INSTR_W = 24,
  parameter int ADDR_W  = 12,
  parameter int DEPTH   = 8      // power of two
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fetchStrobe_t             strb,
  input  logic [ADDR_W-1:0]        pcLoadAddr,
  input  logic [LANES*INSTR_W-1:0] memRdData,
  input  logic                     fifoPop,
  output logic [INSTR_W-1:0]       fifoData,
  output logic                     fifoValid,
  output logic [$clog2(DEPTH+1)-1:0] fifoCount,
  output logic [ADDR_W-1:0]        pcAddr,
  input  logic                     rptReady,
  output logic                     rptValid,
  output logic [ADDR_W-1:0]        rptAddr
);

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int BODY_W = INSTR_W - OP_W;

  logic [INSTR_W-1:0] queueMem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic [ADDR_W-1:0]  pc, pcNext;
  logic               popOk;

  logic [INSTR_W-1:0] laneEntry [LANES];

  // Per-lane entry formation: optional rewrite of the opcode field.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [INSTR_W-1:0] laneWord;
    assign laneWord = memRdData[lane*INSTR_W +: INSTR_W];
    assign laneEntry[lane] = strb.sub[lane] ? {OP_SUSPEND, laneWord[BODY_W-1:0]}
                                            : laneWord;
  end

  assign popOk     = fifoPop && (count != '0);
  assign fifoValid = (count != '0);
  assign fifoData  = queueMem[rdPtr];
  assign fifoCount = count;

  // Lane 0 lands at wrPtr, lane 1 right behind it.
  always_ff @(posedge clk) begin
    if (strb.push[0]) queueMem[wrPtr] <= laneEntry[0];
    if (strb.push[1]) queueMem[wrPtr + PTR_W'(1)] <= laneEntry[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(strb.push[0]) + PTR_W'(strb.push[1]);
      rdPtr <= rdPtr + PTR_W'(popOk);
      count <= count + CNT_W'(strb.push[0]) + CNT_W'(strb.push[1]) - CNT_W'(popOk);
    end
  end

  // Cached program counter.
  always_comb begin
    pcNext = pc;
    if (strb.pcLoad)      pcNext = pcLoadAddr;
    else if (strb.pcAdv1) pcNext = pc + ADDR_W'(1);
    else if (strb.pcAdv2) pcNext = pc + ADDR_W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pc <= '0;
    else       pc <= pcNext;
  end

  assign pcAddr = pc;

  // PC report register, held until accepted.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rptValid <= 1'b0;
      rptAddr  <= '0;
    end else if (strb.rptSet) begin
      rptValid <= 1'b1;
      rptAddr  <= pcNext;
    end else if (rptReady) begin
      rptValid <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push != '0) |-> (count <= CNT_W'(DEPTH - LANES)))
    else $error("queue pushed without room for two entries"); // R11

  AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rptValid && !rptReady && !strb.rptSet) |=> (rptValid && $stable(rptAddr)))
    else $error("report dropped or changed before acceptance"); // R5

  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    strb.push[1] |-> strb.push[0])
    else $error("second lane queued without the first"); // R3

endmodule

// File: rtl/ifetch_ctl.sv
module ifetch_ctl
  import ifetch_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [OP_W-1:0]            op0,
  input  logic [OP_W-1:0]            op1,
  input  logic [$clog2(DEPTH+1)-1:0] fifoCount,
  input  logic                       taskMore,
  input  logic                       pcLoadValid,
  input  logic                       resumeGo,
  input  logic                       suspendDone,
  output fetchStrobe_t               strb,
  output logic                       memRd,
  output logic                       threadIdle
);

  localparam int CNT_W = $clog2(DEPTH+1);

  fetchState_t state, nextState;
  logic        phase, nextPhase;       // 0: address cycle, 1: data cycle
  logic        pullSeen, nextPullSeen; // a PULL already queued this invocation
  logic        room;

  assign room = (fifoCount <= CNT_W'(DEPTH - LANES));

  always_comb begin
    strb         = '0;
    nextState    = state;
    nextPhase    = phase;
    nextPullSeen = pullSeen;
    memRd        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (pcLoadValid) begin
          strb.pcLoad  = 1'b1;
          nextPullSeen = 1'b0;
          nextState    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (!phase) begin
          if (room) begin
            memRd     = 1'b1;
            nextPhase = 1'b1;
          end
        end else begin
          memRd        = 1'b1;
          nextPhase    = 1'b0;
          strb.push[0] = 1'b1;
          strb.sub[0]  = (op0 == OP_PULL) && pullSeen && !taskMore;
          if (op0 == OP_PULL) nextPullSeen = 1'b1;
          if (isStallOp(op0)) begin
            strb.pcAdv1 = 1'b1;
            strb.rptSet = 1'b1;
            nextState   = ST_STALL;
          end else begin
            strb.push[1] = 1'b1;
            strb.sub[1]  = (op1 == OP_PULL) && pullSeen && !taskMore;
            if (op1 == OP_PULL) nextPullSeen = 1'b1;
            strb.pcAdv2  = 1'b1;
            if (isStallOp(op1)) begin
              strb.rptSet = 1'b1;
              nextState   = ST_STALL;
            end
          end
        end
      end
      ST_STALL: begin
        if (pcLoadValid) begin
          strb.pcLoad = 1'b1;
          nextState   = ST_FETCH;
        end else if (resumeGo) begin
          nextState   = ST_FETCH;
        end else if (suspendDone) begin
          strb.rptSet = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      pullSeen <= 1'b0;
    end else begin
      state    <= nextState;
      phase    <= nextPhase;
      pullSeen <= nextPullSeen;
    end
  end

  assign threadIdle = (state == ST_IDLE);

  AST_PUSH_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.push[0] |-> $past(memRd))
    else $error("entry queued without a preceding address cycle"); // R3

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STALL && !pcLoadValid && !resumeGo && !suspendDone) |=> !memRd)
    else $error("memory read while stopped"); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (threadIdle && !pcLoadValid) |=> (threadIdle && !memRd))
    else $error("left idle without a start PC"); // R2

  AST_SUB_ONLY_PULL: assert property (@(posedge clk) disable iff (!rstN)
    strb.sub[0] |-> (op0 == OP_PULL && strb.push[0]))
    else $error("non-PULL entry rewritten"); // R7

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifetch_pkg::*;
#(
  parameter int INSTR_W = 24,
  parameter int ADDR_W  = 12,
  parameter int DEPTH   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memRd,
  input  logic [2*INSTR_W-1:0]     memRdData,
  output logic [INSTR_W-1:0]       fifoData,
  output logic                     fifoValid,
  input  logic                     fifoPop,
  input  logic                     taskMore,
  input  logic                     pcLoadValid,
  input  logic [ADDR_W-1:0]        pcLoadAddr,
  input  logic                     resumeGo,
  input  logic                     suspendDone,
  output logic                     pcRptValid,
  output logic [ADDR_W-1:0]        pcRptAddr,
  input  logic                     pcRptReady,
  output logic                     threadIdle
);

  localparam int CNT_W = $clog2(DEPTH+1);

  fetchStrobe_t     strb;
  logic [CNT_W-1:0] fifoCount;
  logic [OP_W-1:0]  op0, op1;

  assign op0 = memRdData[INSTR_W-1 -: OP_W];
  assign op1 = memRdData[2*INSTR_W-1 -: OP_W];

  ifetch_ctl #(.DEPTH(DEPTH)) i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .op0        (op0),
    .op1        (op1),
    .fifoCount  (fifoCount),
    .taskMore   (taskMore),
    .pcLoadValid(pcLoadValid),
    .resumeGo   (resumeGo),
    .suspendDone(suspendDone),
    .strb       (strb),
    .memRd      (memRd),
    .threadIdle (threadIdle)
  );

  ifetch_dp #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pcLoadAddr(pcLoadAddr),
    .memRdData (memRdData),
    .fifoPop   (fifoPop),
    .fifoData  (fifoData),
    .fifoValid (fifoValid),
    .fifoCount (fifoCount),
    .pcAddr    (memAddr),
    .rptReady  (pcRptReady),
    .rptValid  (pcRptValid),
    .rptAddr   (pcRptAddr)
  );

endmodule

// File: tb/test_ifetch_seq.sv
`timescale 1ns/100ps
module test_ifetch_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] memAddr;
  logic        memRd;
  logic [47:0] memRdData;
  logic [23:0] fifoData;
  logic        fifoValid;
  logic        fifoPop = 1'b0;
  logic        taskMore;
  logic        pcLoadValid;
  logic [11:0] pcLoadAddr;
  logic        resumeGo;
  logic        suspendDone;
  logic        pcRptValid;
  logic [11:0] pcRptAddr;
  logic        pcRptReady;
  logic        threadIdle;

  always #2.5 clk = ~clk;

  ifetch_seq i_ifetch_seq (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd),
    .memRdData(memRdData), .fifoData(fifoData), .fifoValid(fifoValid),
    .fifoPop(fifoPop), .taskMore(taskMore), .pcLoadValid(pcLoadValid),
    .pcLoadAddr(pcLoadAddr), .resumeGo(resumeGo), .suspendDone(suspendDone),
    .pcRptValid(pcRptValid), .pcRptAddr(pcRptAddr), .pcRptReady(pcRptReady),
    .threadIdle(threadIdle)
  );

  // Instruction memory model: two consecutive words, combinational.
  logic [23:0] mem [64];
  logic [5:0]  a0, a1;
  assign a0 = memAddr[5:0];
  assign a1 = a0 + 6'd1;
  assign memRdData = {mem[a1], mem[a0]};

  function automatic logic [23:0] w(input logic [4:0] op, input int addr);
    return {op, 3'b010, 16'(addr)};
  endfunction

  // Expected queue stream for the control-flow program.
  localparam logic [23:0] EXP [12] = '{
    {5'h11, 3'b010, 16'd0},  {5'h13, 3'b010, 16'd1},
    {5'h01, 3'b010, 16'd2},  {5'h01, 3'b010, 16'd3},
    {5'h00, 3'b010, 16'd4},  {5'h01, 3'b010, 16'd8},
    {5'h14, 3'b010, 16'd12}, {5'h03, 3'b010, 16'd13},
    {5'h02, 3'b010, 16'd14}, {5'h1C, 3'b010, 16'd20},
    {5'h12, 3'b010, 16'd21}, {5'h1F, 3'b010, 16'd22}
  };
  localparam string EXP_TAG [12] = '{
    "R2", "R3", "R6", "R7", "R7", "R6", "R9", "R8", "R8", "R9", "R9", "R8"
  };

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Consumer: pops whenever enabled and records each entry.
  logic [23:0] rec [64];
  int          recIdx = 0;
  bit          consumerOn = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (consumerOn && fifoValid && rstN && recIdx < 64) begin
        rec[recIdx] = fifoData;
        recIdx++;
        fifoPop = 1'b1;
      end else begin
        fifoPop = 1'b0;
      end
    end
  end

  task automatic waitRpt(input logic [11:0] exp, input string tag);
    int n = 0;
    while (!pcRptValid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(pcRptValid && pcRptAddr == exp, tag, {19'd0, pcRptValid, pcRptAddr},
          {20'd1, exp});
    pcRptReady = 1'b1;
    @(negedge clk);
    pcRptReady = 1'b0;
  endtask

  task automatic loadPc(input logic [11:0] addr);
    pcLoadValid = 1'b1;
    pcLoadAddr  = addr;
    @(negedge clk);
    pcLoadValid = 1'b0;
  endtask

  task automatic pulseResume();
    resumeGo = 1'b1;
    @(negedge clk);
    resumeGo = 1'b0;
  endtask

  task automatic pulseSuspend();
    suspendDone = 1'b1;
    @(negedge clk);
    suspendDone = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = w(5'h11, i);
    mem[1]  = w(5'h13, 1);
    mem[2]  = w(5'h01, 2);
    mem[3]  = w(5'h01, 3);
    mem[4]  = w(5'h01, 4);
    mem[8]  = w(5'h01, 8);
    mem[12] = w(5'h14, 12);
    mem[13] = w(5'h03, 13);
    mem[14] = w(5'h02, 14);
    mem[20] = w(5'h1C, 20);
    mem[21] = w(5'h12, 21);
    mem[22] = w(5'h1F, 22);

    rstN = 1'b0; taskMore = 1'b0; pcLoadValid = 1'b0; pcLoadAddr = '0;
    resumeGo = 1'b0; suspendDone = 1'b0; pcRptReady = 1'b0;
    repeat (3) @(negedge clk);
    check(!fifoValid, "R1 queue empty", 32'(fifoValid), 0);
    check(!pcRptValid, "R1 no report", 32'(pcRptValid), 0);
    check(threadIdle, "R1 idle", 32'(threadIdle), 1);
    check(!memRd, "R1 no read", 32'(memRd), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(threadIdle && !memRd, "R2 idle waits", {30'd0, threadIdle, memRd}, 32'd2);

    consumerOn = 1'b1;
    loadPc(12'd0);
    waitRpt(12'd3, "R5 stop at first PULL");
    repeat (6) @(negedge clk);
    check(!memRd && !fifoValid, "R4 no fetch while stopped",
          {30'd0, memRd, fifoValid}, 0);
    taskMore = 1'b1;
    pulseResume();
    waitRpt(12'd4, "R5 stop at PULL with more");
    taskMore = 1'b0;
    pulseResume();
    waitRpt(12'd5, "R7 stop at rewritten PULL");
    pulseSuspend();
    waitRpt(12'd5, "R10 suspend report");
    check(threadIdle, "R10 idle after suspend", 32'(threadIdle), 1);

    loadPc(12'd8);
    waitRpt(12'd9, "R6 first PULL of new thread");
    loadPc(12'd12);
    waitRpt(12'd14, "R8 stop at PUT");
    pulseResume();
    waitRpt(12'd15, "R8 stop at JMP");
    loadPc(12'd20);
    waitRpt(12'd21, "R9 stop at IFREG");
    pulseResume();
    waitRpt(12'd23, "R8 stop at START");
    pulseSuspend();
    waitRpt(12'd23, "R10 second suspend report");
    check(threadIdle, "R10 idle", 32'(threadIdle), 1);
    repeat (10) @(negedge clk);

    check(recIdx == 12, "R4 stream length", 32'(recIdx), 32'd12);
    for (int i = 0; i < 12; i++)
      check(rec[i] == EXP[i], EXP_TAG[i], {8'd0, rec[i]}, {8'd0, EXP[i]});

    // R11: slow drain, queue fills and fetching pauses without loss.
    consumerOn = 1'b0;
    @(negedge clk);
    recIdx = 0;
    loadPc(12'd32);
    repeat (40) @(negedge clk);
    check(!memRd && fifoValid, "R11 paused when full", {30'd0, memRd, fifoValid}, 1);
    consumerOn = 1'b1;
    repeat (12) @(negedge clk);
    consumerOn = 1'b0;
    @(negedge clk);
    check(recIdx >= 10, "R11 drained count", 32'(recIdx), 32'd10);
    for (int i = 0; i < 10; i++)
      check(rec[i] == w(5'h11, 32 + i), "R11 order", {8'd0, rec[i]},
            {8'd0, w(5'h11, 32 + i)});

    // R1: reset in the middle of a running thread.
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!fifoValid, "R1 queue cleared", 32'(fifoValid), 0);
    check(threadIdle && !pcRptValid, "R1 idle after reset",
          {30'd0, threadIdle, pcRptValid}, 32'd2);
    finishRun();
  end

endmodule